// File: doc/BRIEF.md
# Reciprocal Constant Divider

This block divides an unsigned operand by a divisor that is fixed when the design is elaborated. It does not iterate. It multiplies the operand by a precomputed reciprocal coefficient and keeps the high part of the product, shifted right. It also returns the remainder, which it recovers from the quotient with one constant multiply and one subtract. The coefficient and the shift are computed from the divisor parameter during elaboration.

Any power-of-two factor in the divisor is split off first and added to the shift. If the remaining odd part is 1, the datapath is a plain shift. Otherwise the coefficient for the odd part is rounded up. If rounding up breaks the error bound, the rounded-down coefficient is used and the operand is incremented before the multiply. The result is registered, so a request accepted on one clock edge is answered one edge later. Elaboration stops on a zero divisor, on a divisor that does not fit the operand width, and on any coefficient that fails the bound.

Top module: `recip_div`

## Requirements
- R1: With the default divisor of 10, `q_o` equals floor(`a_i`/10) for every operand, including 0, 1, 9, 10, 11 and 2^32-1.
- R2: `r_o` equals `a_i` minus the divisor times `q_o`, and is always less than the divisor.
- R3: `out_valid_o` is high in exactly the cycle after a cycle in which `in_valid_i` was sampled high, and low otherwise.
- R4: In a cycle where `in_valid_i` is low, `a_i` is ignored and `q_o` and `r_o` keep the values of the last accepted operand.
- R5: While `rst_ni` is low, `out_valid_o`, `q_o` and `r_o` are all zero.
- R6: A power-of-two divisor (8) returns an exact quotient and remainder using only a shift.
- R7: A divisor whose rounded-up coefficient fails the error bound (7) returns an exact quotient and remainder over the full operand range, including 2^32-1, through the rounded-down coefficient and the operand increment.
- R8: A divisor with a power-of-two factor greater than 2 (100 = 4 x 25) returns an exact quotient and remainder, using the coefficient of its odd part with the factor's exponent added to the shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand present this cycle |
| a_i | input | W | Unsigned dividend |
| out_valid_o | output | 1 | Result present this cycle |
| q_o | output | W | Quotient, held between results |
| r_o | output | W | Remainder, held between results |

## Verification
The properties assume that `in_valid_i` and `a_i` have settled to known levels before each rising edge. They also assume that `in_valid_i` stays low until reset is released. The bench changes every input on the falling edge and keeps `in_valid_i` low throughout reset. It drives idle cycles with random `a_i` so that the hold property sees real input activity. The divisor is a parameter the properties never see change, so the bench builds one instance per divisor class: odd-part, pure shift, rounded-down fallback, and wide power-of-two factor. All four run from one operand stream.

// File: rtl/recip_div_pkg.sv
package recip_div_pkg;

  typedef logic [127:0] wide_t;

  function automatic int unsigned trail_zeros(longint unsigned c);
    longint unsigned v = c;
    int unsigned n = 0;
    while (v != 0 && v[0] == 1'b0) begin
      v = v >> 1;
      n++;
    end
    return n;
  endfunction

  function automatic int unsigned floor_log2(longint unsigned c);
    longint unsigned v = c;
    int unsigned n = 0;
    while (v > 1) begin
      v = v >> 1;
      n++;
    end
    return n;
  endfunction

  // ceil or floor of 2^(w+k)/odd
  function automatic wide_t coef(longint unsigned odd, int unsigned w, int unsigned k, bit up);
    wide_t num = wide_t'(1) << (w + k);
    wide_t den = wide_t'(odd);
    return up ? (num + den - 1) / den : num / den;
  endfunction

  // distance of the coefficient from the exact reciprocal, scaled by odd
  function automatic wide_t coef_err(longint unsigned odd, int unsigned w, int unsigned k, bit up);
    wide_t num = wide_t'(1) << (w + k);
    wide_t m   = coef(odd, w, k, up);
    return up ? m * wide_t'(odd) - num : num - m * wide_t'(odd);
  endfunction

endpackage

// File: rtl/recip_div_quot.sv
module recip_div_quot
  import recip_div_pkg::*;
#(
  parameter int unsigned      W       = 32,
  parameter longint unsigned  DIVISOR = 10
) (
  input  logic [W-1:0] a_i,
  output logic [W-1:0] q_o
);

  localparam int unsigned     TZ    = trail_zeros(DIVISOR);
  localparam longint unsigned ODD   = (DIVISOR == 0) ? 1 : (DIVISOR >> TZ);
  localparam int unsigned     K     = floor_log2(ODD);
  localparam wide_t           M_UP  = coef(ODD, W, K, 1'b1);
  localparam wide_t           M_DN  = coef(ODD, W, K, 1'b0);
  localparam wide_t           BOUND = wide_t'(1) << K;
  localparam bit              UP_OK = coef_err(ODD, W, K, 1'b1) < BOUND;
  localparam bit              DN_OK = coef_err(ODD, W, K, 1'b0) < BOUND;
  localparam wide_t           M_USE = UP_OK ? M_UP : M_DN;
  localparam logic [W-1:0]    M_SEL = M_USE[W-1:0];
  localparam int unsigned     SHIFT = W + K + TZ;
  localparam int unsigned     PW    = 2 * W + 1;

  // elaboration-time legality
  if (W < 2 || W > 32) begin : g_bad_width
    $error("recip_div_quot: W must lie in 2..32");
  end
  if (DIVISOR == 0) begin : g_bad_zero
    $error("recip_div_quot: divisor of zero");
  end
  if (DIVISOR >= (64'd1 << W)) begin : g_bad_range
    $error("recip_div_quot: divisor wider than operand");
  end
  if (ODD > 1 && !UP_OK && !DN_OK) begin : g_bad_coef
    $error("recip_div_quot: no coefficient meets the error bound");
  end
  if (ODD > 1 && (M_USE >> W) != 0) begin : g_bad_fit
    $error("recip_div_quot: coefficient exceeds operand width");
  end

  if (ODD == 1) begin : g_shift
    assign q_o = a_i >> TZ;
  end else if (UP_OK) begin : g_round_up
    assign q_o = W'((PW'(a_i) * PW'(M_SEL)) >> SHIFT);
  end else begin : g_round_dn
    // floor coefficient needs (a+1); extra bit keeps 2^W-1 from wrapping
    assign q_o = W'(((PW'(a_i) + PW'(1)) * PW'(M_SEL)) >> SHIFT);
  end

endmodule

// File: rtl/recip_div_rem.sv
module recip_div_rem #(
  parameter int unsigned     W       = 32,
  parameter longint unsigned DIVISOR = 10
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] q_i,
  output logic [W-1:0] r_o
);

  localparam logic [W-1:0] C_W = W'(DIVISOR);

  // low W bits suffice: the true remainder is below the divisor
  assign r_o = a_i - W'(q_i * C_W);

endmodule

// File: rtl/recip_div.sv
module recip_div #(
  parameter int unsigned     W       = 32,
  parameter longint unsigned DIVISOR = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  input  logic [W-1:0] a_i,
  output logic         out_valid_o,
  output logic [W-1:0] q_o,
  output logic [W-1:0] r_o
);

  localparam logic [W-1:0] C_W  = W'(DIVISOR);
  localparam logic [W-1:0] QMAX = {W{1'b1}} / C_W;

  logic [W-1:0] q_d, r_d;

  recip_div_quot #(.W(W), .DIVISOR(DIVISOR)) u_quot (
    .a_i (a_i),
    .q_o (q_d)
  );

  recip_div_rem #(.W(W), .DIVISOR(DIVISOR)) u_rem (
    .a_i (a_i),
    .q_i (q_d),
    .r_o (r_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      q_o         <= '0;
      r_o         <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        q_o <= q_d;
        r_o <= r_d;
      end
    end
  end

  // R3
  vld_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);

  // R3
  vld_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);

  // R2
  rem_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> r_o < C_W);

  // R1
  quot_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> q_o <= QMAX);

  // R4
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(q_o) && $stable(r_o));

endmodule

// File: tb/recip_div_bench.sv
module recip_div_bench;

  localparam int unsigned W = 32;

  typedef struct packed {
    logic         v;
    logic [W-1:0] a;
  } item_t;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] a = '0;

  logic         v10, v8, v7, v100;
  logic [W-1:0] q10, r10, q8, r8, q7, r7, q100, r100;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  item_t sb_q[$];
  item_t it;
  logic [W-1:0] hold_q = '0;
  logic [W-1:0] hold_r = '0;

  always #2 clk = ~clk;

  recip_div #(.W(W), .DIVISOR(10)) u_recip_div (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .a_i(a),
    .out_valid_o(v10), .q_o(q10), .r_o(r10));

  recip_div #(.W(W), .DIVISOR(8)) u_recip_div_d8 (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .a_i(a),
    .out_valid_o(v8), .q_o(q8), .r_o(r8));

  recip_div #(.W(W), .DIVISOR(7)) u_recip_div_d7 (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .a_i(a),
    .out_valid_o(v7), .q_o(q7), .r_o(r7));

  recip_div #(.W(W), .DIVISOR(100)) u_recip_div_d100 (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .a_i(a),
    .out_valid_o(v100), .q_o(q100), .r_o(r100));

  task automatic chk(string tag, logic [W-1:0] got, logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic send(bit v, logic [W-1:0] x);
    @(negedge clk);
    in_valid = v;
    a        = x;
    sb_q.push_back('{v: v, a: x});
  endtask

  // monitor: results are visible just after the capturing edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_ni && sb_q.size() > 0) begin
        it = sb_q.pop_front();
        chk("R3 valid", W'(v10), W'(it.v));
        chk("R3 valid d8", W'(v8), W'(it.v));
        if (it.v) begin
          chk("R1 quotient /10", q10, it.a / 32'd10);
          chk("R2 remainder /10", r10, it.a % 32'd10);
          chk("R6 quotient /8", q8, it.a / 32'd8);
          chk("R6 remainder /8", r8, it.a % 32'd8);
          chk("R7 quotient /7", q7, it.a / 32'd7);
          chk("R7 remainder /7", r7, it.a % 32'd7);
          chk("R8 quotient /100", q100, it.a / 32'd100);
          chk("R8 remainder /100", r100, it.a % 32'd100);
          chk("R3 valid d7", W'(v7), 32'd1);
          chk("R3 valid d100", W'(v100), 32'd1);
          hold_q = it.a / 32'd10;
          hold_r = it.a % 32'd10;
        end else begin
          chk("R4 hold quotient", q10, hold_q);
          chk("R4 hold remainder", r10, hold_r);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R5
    chk("R5 reset valid", W'(v10), 32'd0);
    chk("R5 reset quotient", q10, 32'd0);
    chk("R5 reset remainder", r10, 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;

    // R1 boundary operands shared by every divisor
    send(1'b1, 32'd0);
    send(1'b1, 32'd1);
    send(1'b1, 32'd6);
    send(1'b1, 32'd7);
    send(1'b1, 32'd8);
    send(1'b1, 32'd9);
    send(1'b1, 32'd10);
    send(1'b1, 32'd11);
    send(1'b1, 32'd99);
    send(1'b1, 32'd100);
    send(1'b1, 32'd101);
    send(1'b1, 32'hFFFF_FFFF);
    send(1'b1, 32'hFFFF_FFFE);
    send(1'b1, 32'hFFFF_FFFA);
    send(1'b1, 32'hFFFF_FFF9);
    send(1'b1, 32'h8000_0000);
    send(1'b1, 32'h7FFF_FFFF);
    // R4 idle cycles with moving operand
    send(1'b0, 32'h1234_5678);
    send(1'b0, 32'hDEAD_BEEF);
    send(1'b1, 32'd4_294_967_290);

    // R7 top of range, every residue mod 7 and 100
    for (int i = 0; i < 256; i++) send(1'b1, 32'hFFFF_FFFF - 32'(i));

    // mixed traffic with gaps
    for (int i = 0; i < 3000; i++) begin
      send(($urandom_range(9) < 7), $urandom());
    end
    for (int i = 0; i < 500; i++) send(1'b1, $urandom_range(2000));

    send(1'b0, 32'd0);
    send(1'b0, 32'd0);
    wait (sb_q.size() == 0);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R3: got %0d pending results expected 0", sb_q.size());
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule